// File: doc/BRIEF.md
# Timer Channel with Selectable Count Clock and Clear Source

This block is one 16-bit up-counting timer channel. An 8-bit control register picks where the count clock comes from, which transitions of that clock advance the counter, and what event returns the counter to zero. The count clock can be one of five taps of a free-running divider on the system clock (/1, /4, /16, /64, /256), or one of three external pins. The external pins are synchronized and edge-detected inside the system clock domain.

The counter can be cleared in three ways. It can clear on a compare match with either of two general registers. It can clear on a synchronous-clear pulse from a neighbouring channel. It can also never clear and simply wrap. A plain register port reads and writes the control register, the counter and both general registers. A phase-mode input from the surrounding timer unit stops the prescaler and edge fields from producing any count.

The register port is a single-cycle control interface with no back-pressure. A write takes effect at the clock edge where `reg_we` is high, and reads are combinational from `reg_addr`. There is no streaming data path, so no valid/ready handshake is used.

Top module: `tmr_chan_ctl`

## Requirements
- R1: After reset, the control register reads 0x0000, the counter reads 0x0000, and both general registers read 0xFFFF. Register addresses are 0 = control, 1 = counter, 2 = general register A, 3 = general register B.
- R2: The control register keeps bits 6:0 of a write. Bit 7 and all upper read bits always read 0, so writing 0xFF reads back 0x007F. Bits 6:5 are the clear select, bits 4:3 the edge select, and bits 2:0 the clock select.
- R3: With clock select 000 (/1), the counter advances on every system clock cycle whatever the edge select holds.
- R4: Clock select 001 is /4. With edge select 00 (rising) or 01 (falling) the counter advances once every 4 cycles. With edge select 1x (both) it advances once every 2 cycles.
- R5: Clock selects 010 (/16), 011 (/64) and 110 (/256) advance the counter once per divide period on a single edge, and twice per period with both edges selected.
- R6: Clock selects 100, 101 and 111 take pins A, C and D. A qualifying pin edge changes the counter at the third system clock edge after the pin changes. Pins that are not selected, and edges the edge select rejects, have no effect.
- R7: Clear select 01 makes the counter go to 0, instead of incrementing, on the count enable where it equals general register A.
- R8: Clear select 10 does the same using general register B.
- R9: Clear select 11 sets the counter to 0 at the clock edge where `sync_clr_in` is high.
- R10: With clear select 00, the counter wraps from 0xFFFF to 0x0000.
- R11: A bus write to the counter takes priority over both counting and clearing in that cycle.
- R12: While `phase_mode` is high, the prescaler and edge fields produce no count, and the counter holds its value.
- R13: `cmp_hit_a` / `cmp_hit_b` are high exactly while a count enable is present and the counter equals general register A / B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| ext_pin_a | input | 1 | External clock pin A |
| ext_pin_c | input | 1 | External clock pin C |
| ext_pin_d | input | 1 | External clock pin D |
| sync_clr_in | input | 1 | Synchronous clear from another channel |
| phase_mode | input | 1 | Phase-counting mode active |
| count_value | output | 16 | Current counter value |
| cmp_hit_a | output | 1 | Compare match with general register A |
| cmp_hit_b | output | 1 | Compare match with general register B |

## Verification
A divider tap decoded at the wrong bit, or an edge strobe that fires twice per edge, changes the counter's increment rate. This is visible on `count_value` within one divide period, and at most 512 cycles for /256. A synchronizer stage too many or too few shifts an external-pin count by one cycle at the third edge after the pin moves. A wrong clear priority or compare decode shows as a nonzero counter in the cycle after a match. The bench therefore measures increment counts over whole-period windows and samples pin and clear responses on the exact cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int CTRL_W = 7;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_CNT  = 2'd1,
    ADR_GRA  = 2'd2,
    ADR_GRB  = 2'd3
  } reg_adr_e;

  typedef enum logic [2:0] {
    CK_DIV1   = 3'b000,
    CK_DIV4   = 3'b001,
    CK_DIV16  = 3'b010,
    CK_DIV64  = 3'b011,
    CK_PIN_A  = 3'b100,
    CK_PIN_C  = 3'b101,
    CK_DIV256 = 3'b110,
    CK_PIN_D  = 3'b111
  } clk_sel_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_GRA  = 2'b01,
    CLR_GRB  = 2'b10,
    CLR_SYNC = 2'b11
  } clr_sel_e;

  typedef struct packed {
    logic [1:0] clr_sel;
    logic [1:0] edge_sel;
    logic [2:0] clk_sel;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int NUM_TAPS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [NUM_TAPS-1:0] tap_rise,
  output logic [NUM_TAPS-1:0] tap_fall
);
  // Tap i sits at bit 2*i+1, giving divide ratios 4, 16, 64, 256, ...
  localparam int DIV_W = 2 * NUM_TAPS;

  logic [DIV_W-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int B = 2 * i + 1;
    // Tap bit has just become 1 with all lower bits 0: rising transition.
    assign tap_rise[i] = (div_cnt[B:0] == {1'b1, {B{1'b0}}});
    // All bits up to the tap are 0: the tap has just fallen.
    assign tap_fall[i] = (div_cnt[B:0] == '0);
  end
endmodule

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-1:0], pin};
  end

  assign rise =  shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
  assign fall = ~shift_q[SYNC_STAGES-1] &  shift_q[SYNC_STAGES];
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  clr_sel_e     clr_sel,
  input  logic         sync_clr,
  input  logic [W-1:0] gra,
  input  logic [W-1:0] grb,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] count,
  output logic         match_a,
  output logic         match_b
);
  logic clear_hit;

  assign match_a = cnt_en && (count == gra);
  assign match_b = cnt_en && (count == grb);

  always_comb begin
    unique case (clr_sel)
      CLR_GRA:  clear_hit = match_a;
      CLR_GRB:  clear_hit = match_b;
      CLR_SYNC: clear_hit = sync_clr;
      default:  clear_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= '0;
    else if (wr_cnt)    count <= wr_val;
    else if (clear_hit) count <= '0;
    else if (cnt_en)    count <= count + 1'b1;
  end
endmodule

// File: rtl/tmr_chan_ctl.sv
module tmr_chan_ctl
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             ext_pin_a,
  input  logic             ext_pin_c,
  input  logic             ext_pin_d,
  input  logic             sync_clr_in,
  input  logic             phase_mode,
  output logic [CNT_W-1:0] count_value,
  output logic             cmp_hit_a,
  output logic             cmp_hit_b
);
  localparam int NUM_TAPS = 4;
  localparam int NUM_PINS = 3;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] gra_q, grb_q;
  logic [NUM_TAPS-1:0] tap_rise, tap_fall;
  logic [NUM_PINS-1:0] pin_in, pin_rise, pin_fall;
  logic             src_rise, src_fall, cnt_en, wr_cnt;

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gra_q  <= '1;
      grb_q  <= '1;
    end else if (reg_we) begin
      unique case (reg_adr_e'(reg_addr))
        ADR_CTRL: ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        ADR_GRA:  gra_q  <= reg_wdata;
        ADR_GRB:  grb_q  <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_adr_e'(reg_addr))
      ADR_CTRL: reg_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      ADR_CNT:  reg_rdata = count_value;
      ADR_GRA:  reg_rdata = gra_q;
      default:  reg_rdata = grb_q;
    endcase
  end

  tmr_prescaler #(.NUM_TAPS(NUM_TAPS)) u_presc (
    .clk(clk), .rst_n(rst_n), .tap_rise(tap_rise), .tap_fall(tap_fall)
  );

  assign pin_in = {ext_pin_d, ext_pin_c, ext_pin_a};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    tmr_ext_edge #(.SYNC_STAGES(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(pin_in[p]),
      .rise(pin_rise[p]), .fall(pin_fall[p])
    );
  end

  // Source selection
  always_comb begin
    src_rise = 1'b0;
    src_fall = 1'b0;
    unique case (clk_sel_e'(ctrl_q.clk_sel))
      CK_DIV4:   begin src_rise = tap_rise[0]; src_fall = tap_fall[0]; end
      CK_DIV16:  begin src_rise = tap_rise[1]; src_fall = tap_fall[1]; end
      CK_DIV64:  begin src_rise = tap_rise[2]; src_fall = tap_fall[2]; end
      CK_DIV256: begin src_rise = tap_rise[3]; src_fall = tap_fall[3]; end
      CK_PIN_A:  begin src_rise = pin_rise[0]; src_fall = pin_fall[0]; end
      CK_PIN_C:  begin src_rise = pin_rise[1]; src_fall = pin_fall[1]; end
      CK_PIN_D:  begin src_rise = pin_rise[2]; src_fall = pin_fall[2]; end
      default:   ;
    endcase
  end

  // Edge qualification; the undivided clock ignores the edge field
  always_comb begin
    if (phase_mode)
      cnt_en = 1'b0;
    else if (clk_sel_e'(ctrl_q.clk_sel) == CK_DIV1)
      cnt_en = 1'b1;
    else if (ctrl_q.edge_sel[1])
      cnt_en = src_rise | src_fall;
    else if (ctrl_q.edge_sel[0])
      cnt_en = src_fall;
    else
      cnt_en = src_rise;
  end

  assign wr_cnt = reg_we && (reg_adr_e'(reg_addr) == ADR_CNT);

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
    .clr_sel(clr_sel_e'(ctrl_q.clr_sel)), .sync_clr(sync_clr_in),
    .gra(gra_q), .grb(grb_q), .wr_cnt(wr_cnt), .wr_val(reg_wdata),
    .count(count_value), .match_a(cmp_hit_a), .match_b(cmp_hit_b)
  );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        sync_clr_in,
  input logic        phase_mode,
  input logic [6:0]  ctrl_q,
  input logic [15:0] count_value
);
  logic cnt_wr;
  assign cnt_wr = reg_we && (reg_addr == 2'd1);

  p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[15:7] == 9'd0));

  p_div1_every_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_mode && ctrl_q[2:0] == 3'b000 && ctrl_q[6:5] == 2'b00 && !cnt_wr)
    |=> (count_value == 16'($past(count_value) + 16'd1)));

  p_sync_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6:5] == 2'b11 && sync_clr_in && !cnt_wr) |=> (count_value == 16'd0));

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_value == $past(reg_wdata)));

  p_phase_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_mode && !cnt_wr && ctrl_q[6:5] != 2'b11) |=> $stable(count_value));
endmodule

bind tmr_chan_ctl tmr_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_clr_in(sync_clr_in),
  .phase_mode(phase_mode), .ctrl_q(ctrl_q), .count_value(count_value)
);

// File: tb/tmr_chan_ctl_bench.sv
`timescale 1ns/1ps
module tmr_chan_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        ext_pin_a = 1'b0, ext_pin_c = 1'b0, ext_pin_d = 1'b0;
  logic        sync_clr_in = 1'b0, phase_mode = 1'b0;
  logic [15:0] count_value;
  logic        cmp_hit_a, cmp_hit_b;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_chan_ctl u_tmr_chan_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin_a(ext_pin_a),
    .ext_pin_c(ext_pin_c), .ext_pin_d(ext_pin_d), .sync_clr_in(sync_clr_in),
    .phase_mode(phase_mode), .count_value(count_value),
    .cmp_hit_a(cmp_hit_a), .cmp_hit_b(cmp_hit_b)
  );

  // {ctrl, cycles, expected increments}; windows are whole divide periods
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {8'h00, 16'd40,  16'd40},  // R3 /1 rising
    {8'h10, 16'd40,  16'd40},  // R3 /1 both edges ignored
    {8'h01, 16'd40,  16'd10},  // R4 /4 rising
    {8'h09, 16'd40,  16'd10},  // R4 /4 falling
    {8'h11, 16'd40,  16'd20},  // R4 /4 both
    {8'h02, 16'd64,  16'd4},   // R5 /16 rising
    {8'h13, 16'd128, 16'd4},   // R5 /64 both
    {8'h0B, 16'd128, 16'd2},   // R5 /64 falling
    {8'h06, 16'd512, 16'd2},   // R5 /256 rising
    {8'h1E, 16'd512, 16'd4}    // R5 /256 both
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge; returns at the negedge after
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    wait_n(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); check("R1 cnt", v, 16'h0000);
    rd(2'd2, v); check("R1 gra", v, 16'hFFFF);
    rd(2'd3, v); check("R1 grb", v, 16'hFFFF);
    @(negedge clk);
    // R2 reserved bit
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); check("R2 ctrl readback", v, 16'h007F);
    @(negedge clk);

    // Rate table for R3 / R4 / R5
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {8'h00, VEC[i][39:32]});
      wr(2'd1, 16'h0000);
      wait_n(int'(VEC[i][31:16]));
      check($sformatf("R3/R4/R5 rate vec %0d", i), count_value, VEC[i][15:0]);
    end

    // R6 pin A rising, three-edge latency
    wr(2'd0, 16'h0004);
    wr(2'd1, 16'h0000);
    ext_pin_a = 1'b1;
    wait_n(2); check("R6 pinA before latency", count_value, 16'd0);
    wait_n(1); check("R6 pinA rise", count_value, 16'd1);
    ext_pin_d = 1'b1;
    wait_n(4); check("R6 unselected pin D ignored", count_value, 16'd1);
    ext_pin_a = 1'b0;
    wait_n(4); check("R6 pinA fall rejected", count_value, 16'd1);
    ext_pin_d = 1'b0;
    wait_n(4);
    // R6 pin C falling
    wr(2'd0, 16'h000D);
    ext_pin_c = 1'b1;
    wait_n(4);
    wr(2'd1, 16'h0000);
    ext_pin_c = 1'b0;
    wait_n(3); check("R6 pinC falling", count_value, 16'd1);
    // R6 pin D both edges
    wr(2'd0, 16'h0017);
    wr(2'd1, 16'h0000);
    ext_pin_d = 1'b1;
    wait_n(4);
    ext_pin_d = 1'b0;
    wait_n(4); check("R6 pinD both", count_value, 16'd2);

    // R7 / R13 clear on GRA
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0020);
    wr(2'd1, 16'h0000);
    wait_n(5);
    check("R7 reaches GRA", count_value, 16'd5);
    check("R13 hit A", {15'd0, cmp_hit_a}, 16'd1);
    check("R13 no hit B", {15'd0, cmp_hit_b}, 16'd0);
    wait_n(1); check("R7 cleared on GRA", count_value, 16'd0);
    // R11 write beats clear
    wr(2'd1, 16'd4);
    wait_n(1); check("R11 pre", count_value, 16'd5);
    wr(2'd1, 16'd9); check("R11 write over clear", count_value, 16'd9);

    // R8 clear on GRB
    wr(2'd3, 16'd3);
    wr(2'd0, 16'h0040);
    wr(2'd1, 16'h0000);
    wait_n(3);
    check("R8 reaches GRB", count_value, 16'd3);
    check("R13 hit B", {15'd0, cmp_hit_b}, 16'd1);
    wait_n(1); check("R8 cleared on GRB", count_value, 16'd0);

    // R9 sync clear
    wr(2'd0, 16'h0060);
    wr(2'd1, 16'h0000);
    wait_n(7); check("R9 counting", count_value, 16'd7);
    sync_clr_in = 1'b1;
    wait_n(1); check("R9 sync cleared", count_value, 16'd0);
    sync_clr_in = 1'b0;
    wait_n(1); check("R9 resumes", count_value, 16'd1);

    // R10 wrap
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hFFFE);
    wait_n(1); check("R10 at max", count_value, 16'hFFFF);
    wait_n(1); check("R10 wraps", count_value, 16'h0000);

    // R12 phase mode hold
    phase_mode = 1'b1;
    wr(2'd1, 16'h0000);
    wait_n(10); check("R12 /1 held", count_value, 16'd0);
    wr(2'd0, 16'h0011);
    wait_n(16); check("R12 /4 both held", count_value, 16'd0);
    phase_mode = 1'b0;
    wait_n(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule